// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier with Alpha-Power Stepper

This block multiplies two elements of GF(2^12) and hands back their 12-bit product. The field is not built on one degree-12 polynomial. It is a quadratic extension over GF(64), and GF(64) is reduced by x^6 + x + 1. An element is written as a pair of 6-bit halves. The product is formed from four GF(64) sub-products combined with XOR, and one of those sub-products is scaled by the fixed extension constant 0x21. The arithmetic serves Reed-Solomon style error-correction logic that works on 12-bit symbols.

Operand pairs come in on a valid/ready stream and products leave on a second valid/ready stream. A transfer happens on a rising clock edge at which both valid and ready are high. By default one output register holds the product. That register may be refilled in the same cycle it is drained, so the input side sees back-pressure only while a result is waiting and the consumer is not taking it.

A separate power register produces the successive powers of the non-canonical generator 0xE01. It leaves reset holding 1, and each cycle with the step control high multiplies it by the generator. Syndrome-evaluation or table-building logic can therefore walk alpha^0, alpha^1, alpha^2 and so on. If the register ever held zero, the step function would map it to 1.

Top module: `gf12_tower_unit`

## Requirements
- R1: While reset is low and in the first cycle after it rises, `res_valid` is 0, `op_ready` is 1 and `alpha_pow` is 0x001.
- R2: For a = {ah, al} and b = {bh, bl}, with ah and bh in bits [11:6] and al and bl in bits [5:0], the product's bits [11:6] are m(ah^al, bh^bl) ^ m(al, bl) and its bits [5:0] are m(m(ah, bh), 0x21) ^ m(al, bl). Here m is GF(64) multiplication reduced by x^6 + x + 1 (mask 0x43).
- R3: Multiplying any operand by 0x001 returns that operand, and multiplying by 0x000 returns 0x000.
- R4: The product of (a, b) equals the product of (b, a).
- R5: An operand pair taken in on a clock edge appears on `res_prod` with `res_valid` high right after that edge, so latency is one cycle. `op_ready` equals `!res_valid || res_ready`.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_prod` keeps its value across the following edge.
- R7: Each accepted operand pair yields exactly one result, and results leave in the order their operands were accepted.
- R8: On each edge where `step_en` is high, `alpha_pow` becomes its previous value times 0xE01, so after k steps since reset it holds 0xE01^k.
- R9: On an edge where `step_en` is low, `alpha_pow` keeps its value, and operand or result traffic has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand pair present |
| op_ready | output | 1 | Block accepts an operand pair this cycle |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand |
| res_valid | output | 1 | Product present |
| res_ready | input | 1 | Consumer accepts the product this cycle |
| res_prod | output | 12 | Product of the accepted operands |
| step_en | input | 1 | Advance the power register by one generator multiply |
| alpha_pow | output | 12 | Current generator power |

## Verification
A wrong GF(64) reduction tap or a swapped half in the tower recombination changes the product one cycle after the pair is accepted. Random operands expose it at once, while the multiply-by-one and multiply-by-zero pairs pin down which half is at fault. A fault in the handshake register shows up as a lost, repeated or reordered result, or as a product that changes while stalled, and it is caught on the first stalled or drained cycle. A wrong generator constant or a wrong step term makes `alpha_pow` diverge from the expected power on the first step, and the error then carries through every later power.

// File: rtl/gf12_pkg.sv
package gf12_pkg;
  // Width of one half of an element; the full element is twice this.
  localparam int unsigned HALF_W    = 6;
  localparam int unsigned FULL_W    = 2 * HALF_W;
  // Base-field reduction: x^6 + x + 1, including the x^6 term.
  localparam logic [HALF_W:0]   BASE_POLY = 7'h43;
  // Constant of the quadratic extension x^2 + x + c over GF(64).
  localparam logic [HALF_W-1:0] EXT_C     = 6'h21;
  // Generator used by the power stepper.
  localparam logic [FULL_W-1:0] GEN_ALPHA = 12'hE01;
  // Register stages between the operand and result streams (0 or 1).
  localparam int unsigned PIPE_DEF  = 1;
endpackage

// File: rtl/gf12_sub_mul.sv
// GF(2^W) multiply as an unrolled shift-and-XOR chain.
module gf12_sub_mul #(
  parameter int unsigned W    = gf12_pkg::HALF_W,
  parameter logic [W:0]  POLY = gf12_pkg::BASE_POLY
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  // acc[k] holds the partial sum after k bits of a; sh[k] = b * x^k mod POLY.
  logic [W-1:0] acc [0:W];
  logic [W-1:0] sh  [0:W-1];

  assign acc[0] = '0;
  assign sh[0]  = b;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign acc[k+1] = acc[k] ^ ({W{a[k]}} & sh[k]);
    if (k < W - 1) begin : g_shift
      // When the top bit leaves, fold x^W back as the low taps of POLY.
      assign sh[k+1] = {sh[k][W-2:0], 1'b0} ^ ({W{sh[k][W-1]}} & POLY[W-1:0]);
    end
  end

  assign p = acc[W];
endmodule

// File: rtl/gf12_tower_mul.sv
// Degree-2 extension multiply over GF(2^HW): four base multiplies.
module gf12_tower_mul #(
  parameter int unsigned HW   = gf12_pkg::HALF_W,
  parameter logic [HW:0] POLY = gf12_pkg::BASE_POLY,
  parameter logic [HW-1:0] EXT = gf12_pkg::EXT_C,
  localparam int unsigned FW  = 2 * HW
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic [FW-1:0] p
);
  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [HW-1:0] m_cross, m_lo, m_hi, m_twist;

  assign a_hi = a[FW-1:HW];
  assign a_lo = a[HW-1:0];
  assign b_hi = b[FW-1:HW];
  assign b_lo = b[HW-1:0];

  gf12_sub_mul #(.W(HW), .POLY(POLY)) u_cross (
    .a(a_hi ^ a_lo), .b(b_hi ^ b_lo), .p(m_cross));
  gf12_sub_mul #(.W(HW), .POLY(POLY)) u_lo (
    .a(a_lo), .b(b_lo), .p(m_lo));
  gf12_sub_mul #(.W(HW), .POLY(POLY)) u_hi (
    .a(a_hi), .b(b_hi), .p(m_hi));
  // High-by-high term is scaled by the extension constant before folding low.
  gf12_sub_mul #(.W(HW), .POLY(POLY)) u_twist (
    .a(m_hi), .b(EXT), .p(m_twist));

  assign p = {m_cross ^ m_lo, m_twist ^ m_lo};
endmodule

// File: rtl/gf12_mul_stream.sv
// Valid/ready wrapper around the tower multiply.
module gf12_mul_stream #(
  parameter int unsigned HW    = gf12_pkg::HALF_W,
  parameter logic [HW:0] POLY  = gf12_pkg::BASE_POLY,
  parameter logic [HW-1:0] EXT = gf12_pkg::EXT_C,
  parameter int unsigned STAGES = gf12_pkg::PIPE_DEF,
  localparam int unsigned FW   = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_a,
  input  logic [FW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_prod
);
  logic [FW-1:0] prod_c;

  gf12_tower_mul #(.HW(HW), .POLY(POLY), .EXT(EXT)) u_core (
    .a(in_a), .b(in_b), .p(prod_c));

  if (STAGES == 0) begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = prod_c;
  end else begin : g_reg
    logic          vld_q;
    logic [FW-1:0] prod_q;

    // The slot may be refilled on the edge it drains.
    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end

    assign out_valid = vld_q;
    assign out_prod  = prod_q;

    a_r5_take_then_show: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_prod));
  end

  a_r3_times_one: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_b == FW'(1) |-> prod_c == in_a);
  a_r3_times_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_b == '0 |-> prod_c == '0);
endmodule

// File: rtl/gf12_alpha_stepper.sv
// Power register advanced by a fixed generator multiply.
module gf12_alpha_stepper #(
  parameter int unsigned HW    = gf12_pkg::HALF_W,
  parameter logic [HW:0] POLY  = gf12_pkg::BASE_POLY,
  parameter logic [HW-1:0] EXT = gf12_pkg::EXT_C,
  localparam int unsigned FW   = 2 * HW,
  parameter logic [FW-1:0] GEN = gf12_pkg::GEN_ALPHA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [FW-1:0] power
);
  logic [FW-1:0] pow_q, times_gen, next_pow;

  gf12_tower_mul #(.HW(HW), .POLY(POLY), .EXT(EXT)) u_gen (
    .a(pow_q), .b(GEN), .p(times_gen));

  // A zero state restarts the sequence at the identity.
  assign next_pow = (pow_q == '0) ? FW'(1) : times_gen;

  always_ff @(posedge clk) begin
    if (!rst_n)    pow_q <= FW'(1);
    else if (step) pow_q <= next_pow;
  end

  assign power = pow_q;

  a_r8_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> power != $past(power));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(power));
  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    power != '0);
endmodule

// File: rtl/gf12_tower_unit.sv
module gf12_tower_unit #(
  parameter int unsigned HW     = gf12_pkg::HALF_W,
  parameter int unsigned STAGES = gf12_pkg::PIPE_DEF,
  localparam int unsigned FW    = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [FW-1:0] op_a,
  input  logic [FW-1:0] op_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [FW-1:0] res_prod,
  input  logic          step_en,
  output logic [FW-1:0] alpha_pow
);
  gf12_mul_stream #(.HW(HW), .STAGES(STAGES)) u_stream (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_ready(op_ready),
    .in_a(op_a), .in_b(op_b),
    .out_valid(res_valid), .out_ready(res_ready), .out_prod(res_prod));

  gf12_alpha_stepper #(.HW(HW)) u_step (
    .clk(clk), .rst_n(rst_n), .step(step_en), .power(alpha_pow));
endmodule

// File: tb/gf12_tower_unit_tb.sv
module gf12_tower_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, res_ready = 1'b0, step_en = 1'b0;
  logic [11:0] op_a = '0, op_b = '0;
  logic        op_ready, res_valid;
  logic [11:0] res_prod, alpha_pow;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  int          tag_q[$];
  logic [11:0] pow_model = 12'h001;
  logic [11:0] swap_ref = '0;
  bit          hold_prev = 0, expect_vld = 0;
  logic [11:0] held_val = '0;

  always #4 clk = ~clk;

  gf12_tower_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_prod(res_prod), .step_en(step_en), .alpha_pow(alpha_pow));

  // Reference GF(64): carry-less product, then long division by 0x43.
  function automatic logic [5:0] ref_m6(logic [5:0] a, logic [5:0] b);
    logic [10:0] t = '0;
    for (int i = 0; i < 6; i++) if (b[i]) t ^= 11'(a) << i;
    for (int i = 10; i >= 6; i--) if (t[i]) t ^= 11'h43 << (i - 6);
    return t[5:0];
  endfunction

  function automatic logic [11:0] ref_m12(logic [11:0] a, logic [11:0] b);
    logic [5:0] hi, lo;
    lo = ref_m6(b[5:0], a[5:0]);
    hi = ref_m6(b[11:6] ^ b[5:0], a[11:6] ^ a[5:0]) ^ lo;
    return {hi, ref_m6(6'h21, ref_m6(b[11:6], a[11:6])) ^ lo};
  endfunction

  task automatic chk(bit ok, string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  // One cycle: check state, drive, then account for the coming edge.
  task automatic cyc(bit v, logic [11:0] a, logic [11:0] b, int tag,
                     bit rdy, bit stp, output bit took);
    @(negedge clk);
    if (expect_vld) chk(res_valid == 1'b1, "R5 latency", 12'(res_valid), 12'h1);
    if (hold_prev) begin
      chk(res_valid == 1'b1, "R6 valid held", 12'(res_valid), 12'h1);
      chk(res_prod == held_val, "R6 value held", res_prod, held_val);
    end
    chk(alpha_pow == pow_model, "R8/R9 power", alpha_pow, pow_model);
    res_ready = rdy; op_valid = v; op_a = a; op_b = b; step_en = stp;
    #1;
    chk(op_ready == (!res_valid || res_ready), "R5 ready rule",
        12'(op_ready), 12'(!res_valid || res_ready));
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 extra result", res_prod, '0);
      end else begin
        logic [11:0] e = exp_q.pop_front();
        int t = tag_q.pop_front();
        case (t)
          1: chk(res_prod == e, "R3 identity/zero", res_prod, e);
          2: begin chk(res_prod == e, "R4 first order", res_prod, e); swap_ref = res_prod; end
          3: chk(res_prod == swap_ref, "R4 swapped order", res_prod, swap_ref);
          default: chk(res_prod == e, "R2 product", res_prod, e);
        endcase
      end
    end
    hold_prev = res_valid && !res_ready;
    held_val  = res_prod;
    took = op_valid && op_ready;
    expect_vld = took;
    if (took) begin exp_q.push_back(ref_m12(a, b)); tag_q.push_back(tag); end
    if (stp) pow_model = ref_m12(pow_model, 12'hE01);
  endtask

  task automatic send(logic [11:0] a, logic [11:0] b, int tag);
    bit took = 0;
    while (!took) cyc(1, a, b, tag, ($urandom % 4) != 0, 0, took);
  endtask

  initial begin
    bit tk;
    logic [11:0] corner [8];
    void'($urandom(32'd1234));
    corner = '{12'h000, 12'h001, 12'hFFF, 12'h040, 12'h03F, 12'hFC0, 12'hE01, 12'h555};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 0, "R1 reset valid", 12'(res_valid), 12'h0);
    chk(alpha_pow == 12'h001, "R1 reset power", alpha_pow, 12'h001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 0, "R1 post-reset valid", 12'(res_valid), 12'h0);
    chk(op_ready == 1, "R1 post-reset ready", 12'(op_ready), 12'h1);
    chk(alpha_pow == 12'h001, "R1 post-reset power", alpha_pow, 12'h001);

    // Identity and zero on both sides (R3).
    for (int i = 0; i < 8; i++) begin
      send(corner[i], 12'h001, 1); send(12'h001, corner[i], 1);
      send(corner[i], 12'h000, 1); send(12'h000, corner[i], 1);
    end
    // Swapped pairs over corners (R4).
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        send(corner[i], corner[j], 2); send(corner[j], corner[i], 2 + 1);
      end
    // Long stall with a full slot (R6) and drain.
    send(12'hABC, 12'h123, 0);
    repeat (5) cyc(0, '0, '0, 0, 0, 0, tk);
    repeat (4) cyc(0, '0, '0, 0, 1, 0, tk);
    // Random traffic with random stepping (R2, R7, R8, R9).
    for (int n = 0; n < 3000; n++)
      cyc(($urandom % 3) != 0, 12'($urandom), 12'($urandom), 0,
          ($urandom % 3) != 0, ($urandom % 2) == 0, tk);
    // Full-length power walk (R8).
    for (int n = 0; n < 4100; n++) cyc(0, '0, '0, 0, 1, 1, tk);
    repeat (3) cyc(0, '0, '0, 0, 1, 0, tk);
    chk(exp_q.size() == 0, "R7 all results delivered", 12'(exp_q.size()), 12'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule